// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a bank of digital input lines and raises a single interrupt line when a programmed subset of them meets a condition. Only a fixed window of channels (4 through 19 with the default parameters) can take part. Each channel has two select bits, spread over two mode words. The first selects "rising edge / high level" and the second selects "falling edge / low level".

Two ways of combining the channels are available. In edge (OR) mode, any selected channel that sees one of its selected edges fires the interrupt. In level (AND) mode, the interrupt fires once every selected channel sits at its selected level at the same time. After such a firing, the level logic stays blocked until one of the selected inputs changes level. Software reads the raw inputs, the two mode words and a status word through a small word-addressed register port. Reading the status word clears it. Software acknowledges an interrupt by writing the control word with enable cleared and then writing it again with enable set.

Top module: `cosIrqCtrl`

## Requirements
- R1: After reset, the interrupt output is low, and the two mode words, the control word and the status word all read as zero.
- R2: Writes to the mode words at offsets 0x04 and 0x08 keep only bits [19:4]; all other bits read back as zero. The control word at offset 0x10 keeps only bit 2 (enable) and bit 1 (1 = AND/level, 0 = OR/edge).
- R3: Offset 0x00 reads the input pins after a two-flop synchronizer. It tracks the pins whether or not the interrupt is enabled.
- R4: In OR mode with enable set (control = 0x4), a channel whose bit is set in the 0x04 word fires on a rising edge, and a channel whose bit is set in the 0x08 word fires on a falling edge. The interrupt goes high, and the status word gains a bit for each channel that fired.
- R5: In OR mode, a channel with both bits set fires on either edge. A channel with neither bit set, or one outside [19:4], never fires.
- R6: In AND mode with enable set (control = 0x6), the interrupt fires when every channel with a set bit is at its level: high for a 0x04 bit, low for a 0x08 bit, and always satisfied with both bits set. The status word then gains the set of selected channels.
- R7: After an AND-mode firing, no further firing happens until at least one selected channel changes level, even if the condition still holds after acknowledgement.
- R8: In AND mode with no channel selected, the interrupt never fires.
- R9: The interrupt output stays high until a write to the control word clears bit 2, and drops on the next cycle. Writing enable back on re-arms it.
- R10: A read of offset 0x0C returns the latched status and clears it, so an immediate second read returns zero.
- R11: With enable clear, input activity latches nothing: the interrupt stays low and the status word stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinsIn | input | 32 | Asynchronous digital input lines |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears status on offset 0x0C) |
| addr | input | 5 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irqOut | output | 1 | Level interrupt, held until acknowledged |

## Verification
A wrong edge or level evaluation shows up on `irqOut` and in the status word three clock edges after a pin change. That delay comes from two synchronizer flops and one latch stage. A stuck re-arm flag shows up in level mode in two ways: the interrupt fires again right after acknowledgement, or it never fires again after a selected channel toggles away and back. A status word that does not clear on read is visible on the next read of 0x0C. Mode words with bits outside the channel window show up directly on read-back, and also as interrupts from out-of-window pins.

// File: rtl/cosPkg.sv
package cosPkg;
  localparam int OFF_RAW  = 'h00;
  localparam int OFF_MODE1 = 'h04;
  localparam int OFF_MODE2 = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_CTRL = 'h10;
  localparam int BIT_EN   = 2;
  localparam int BIT_AND  = 1;

  typedef struct packed {
    logic clrStatus;
    logic latchOr;
    logic latchAnd;
  } cosStrobeT;
endpackage

// File: rtl/cosDatapath.sv
module cosDatapath
  import cosPkg::*;
#(
  parameter int N_PINS = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [N_PINS-1:0] CH_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_PINS-1:0] pinsIn,
  input  logic [N_PINS-1:0] mode1,
  input  logic [N_PINS-1:0] mode2,
  input  cosStrobeT         strb,
  output logic [N_PINS-1:0] rawIn,
  output logic [N_PINS-1:0] status,
  output logic              orHit,
  output logic              andMet,
  output logic              selChange
);
  logic [N_PINS-1:0] syncQ [SYNC_STAGES];
  logic [N_PINS-1:0] prevQ;
  logic [N_PINS-1:0] curS;
  logic [N_PINS-1:0] hitVec;
  logic [N_PINS-1:0] satVec;
  logic [N_PINS-1:0] selMask;
  logic [N_PINS-1:0] statusQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinsIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign curS = syncQ[SYNC_STAGES-1];
  assign rawIn = curS;

  for (genvar g = 0; g < N_PINS; g++) begin : g_ch
    assign hitVec[g] = (mode1[g] & curS[g] & ~prevQ[g]) |
                       (mode2[g] & ~curS[g] & prevQ[g]);
    assign satVec[g] = ~(mode1[g] | mode2[g]) | (mode1[g] & mode2[g]) |
                       (mode1[g] & curS[g]) | (mode2[g] & ~curS[g]);
  end

  assign selMask   = (mode1 | mode2) & CH_MASK;
  assign orHit     = |(hitVec & CH_MASK);
  assign andMet    = (|selMask) & (&satVec);
  assign selChange = |((curS ^ prevQ) & selMask);

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else statusQ <= (strb.clrStatus ? '0 : statusQ) |
                    (strb.latchOr  ? (hitVec & CH_MASK) : '0) |
                    (strb.latchAnd ? selMask : '0);
  end
  assign status = statusQ;

  // R4
  latch_or_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchOr |-> orHit);

  // R10
  status_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.clrStatus) && !$past(strb.latchOr) && !$past(strb.latchAnd))
      |-> statusQ == '0);
endmodule

// File: rtl/cosControl.sv
module cosControl
  import cosPkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 5,
  parameter logic [N_PINS-1:0] CH_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wrData,
  input  logic              orHit,
  input  logic              andMet,
  input  logic              selChange,
  output cosStrobeT         strb,
  output logic [N_PINS-1:0] mode1,
  output logic [N_PINS-1:0] mode2,
  output logic              ctrlEn,
  output logic              ctrlAnd,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_M1   = ADDR_W'(OFF_MODE1);
  localparam logic [ADDR_W-1:0] A_M2   = ADDR_W'(OFF_MODE2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic [N_PINS-1:0] mode1Q, mode2Q;
  logic enQ, andQ, irqQ, armedQ;
  logic wrCtrl, ackClr, fireOr, fireAnd;

  assign wrCtrl  = wrEn && (addr == A_CTRL);
  assign ackClr  = wrCtrl && !wrData[BIT_EN];
  assign fireOr  = enQ && !andQ && orHit;
  assign fireAnd = enQ && andQ && armedQ && andMet;

  always_comb begin
    strb.clrStatus = rdEn && (addr == A_STAT);
    strb.latchOr   = fireOr;
    strb.latchAnd  = fireAnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode1Q <= '0;
      mode2Q <= '0;
      enQ    <= 1'b0;
      andQ   <= 1'b0;
    end else begin
      if (wrEn && addr == A_M1) mode1Q <= wrData & CH_MASK;
      if (wrEn && addr == A_M2) mode2Q <= wrData & CH_MASK;
      if (wrCtrl) begin
        enQ  <= wrData[BIT_EN];
        andQ <= wrData[BIT_AND];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ   <= 1'b0;
      armedQ <= 1'b1;
    end else begin
      if (ackClr) irqQ <= 1'b0;
      else if (fireOr || fireAnd) irqQ <= 1'b1;
      if (fireAnd) armedQ <= 1'b0;
      else if (selChange) armedQ <= 1'b1;
    end
  end

  assign mode1   = mode1Q;
  assign mode2   = mode2Q;
  assign ctrlEn  = enQ;
  assign ctrlAnd = andQ;
  assign irq     = irqQ;

  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqQ) |-> $past(ackClr));

  // R11
  irq_rise_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(enQ));

  // R7
  and_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqQ) && $past(andQ)) |-> $past(armedQ));
endmodule

// File: rtl/cosIrqCtrl.sv
module cosIrqCtrl
  import cosPkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CH_LO = 4,
  parameter int CH_HI = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_PINS-1:0] pinsIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wrData,
  output logic [N_PINS-1:0] rdData,
  output logic              irqOut
);
  localparam logic [N_PINS-1:0] CH_MASK =
    ({N_PINS{1'b1}} >> (N_PINS - 1 - CH_HI)) & ({N_PINS{1'b1}} << CH_LO);

  cosStrobeT strb;
  logic [N_PINS-1:0] mode1, mode2, rawIn, status;
  logic orHit, andMet, selChange, ctrlEn, ctrlAnd;

  cosControl #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .CH_MASK(CH_MASK)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .orHit(orHit), .andMet(andMet), .selChange(selChange),
    .strb(strb), .mode1(mode1), .mode2(mode2), .ctrlEn(ctrlEn),
    .ctrlAnd(ctrlAnd), .irq(irqOut)
  );

  cosDatapath #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES), .CH_MASK(CH_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .mode1(mode1), .mode2(mode2),
    .strb(strb), .rawIn(rawIn), .status(status), .orHit(orHit),
    .andMet(andMet), .selChange(selChange)
  );

  always_comb begin
    rdData = '0;
    case (int'(addr))
      OFF_RAW:   rdData = rawIn;
      OFF_MODE1: rdData = mode1;
      OFF_MODE2: rdData = mode2;
      OFF_STAT:  rdData = status;
      OFF_CTRL: begin
        rdData[BIT_EN]  = ctrlEn;
        rdData[BIT_AND] = ctrlAnd;
      end
      default:   rdData = '0;
    endcase
  end
endmodule

// File: tb/cosIrqCtrl_tb.sv
`timescale 1ns/1ps
module cosIrqCtrl_tb;
  localparam logic [31:0] WIN = 32'h000F_FFF0;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] pinsIn = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irqOut;
  int total = 0, bad = 0;
  bit finished = 0;

  cosIrqCtrl u_dut (.clk(clk), .rstN(rstN), .pinsIn(pinsIn), .wrEn(wrEn),
    .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut));

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rdReg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1; addr = a; #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic ackAll();
    logic [31:0] junk;
    logic [31:0] c;
    rdReg(5'h10, c);
    wrReg(5'h10, c & ~32'h4);
    wrReg(5'h10, c);
    rdReg(5'h0C, junk);
  endtask

  function automatic logic [31:0] orHits(logic [31:0] p, logic [31:0] c,
                                         logic [31:0] m1, logic [31:0] m2);
    return ((m1 & c & ~p) | (m2 & ~c & p)) & WIN;
  endfunction

  initial begin
    logic [31:0] v, m1, m2, nxt, exp;
    logic [31:0] prevPins;
    void'($urandom(32'd4242));
    cyc(3); rstN = 1; cyc(2);
    // R1 reset state
    chk("R1 irq", {31'd0, irqOut}, 0);
    rdReg(5'h04, v); chk("R1 mode1", v, 0);
    rdReg(5'h08, v); chk("R1 mode2", v, 0);
    rdReg(5'h10, v); chk("R1 ctrl", v, 0);
    rdReg(5'h0C, v); chk("R1 status", v, 0);
    // R2 masking
    wrReg(5'h04, 32'hFFFF_FFFF); rdReg(5'h04, v); chk("R2 mode1 mask", v, WIN);
    wrReg(5'h08, 32'hFFFF_FFFF); rdReg(5'h08, v); chk("R2 mode2 mask", v, WIN);
    wrReg(5'h10, 32'hFFFF_FFFF); rdReg(5'h10, v); chk("R2 ctrl mask", v, 32'h6);
    wrReg(5'h10, 0); wrReg(5'h04, 0); wrReg(5'h08, 0); rdReg(5'h0C, v);
    // R11 and R3: disabled, masks set, raw tracks pins
    wrReg(5'h04, WIN); wrReg(5'h08, WIN);
    pinsIn = 32'hA5A5_5A5A; cyc(5);
    rdReg(5'h00, v); chk("R3 raw disabled", v, 32'hA5A5_5A5A);
    chk("R11 irq stays low", {31'd0, irqOut}, 0);
    rdReg(5'h0C, v); chk("R11 status zero", v, 0);
    pinsIn = 32'h0; cyc(5);
    chk("R11 irq stays low 2", {31'd0, irqOut}, 0);
    // R4 directed rising edge on ch 7
    wrReg(5'h04, 32'h80); wrReg(5'h08, 32'h0); wrReg(5'h10, 32'h4);
    pinsIn = 32'h80; cyc(5);
    chk("R4 irq rise", {31'd0, irqOut}, 1);
    cyc(3); chk("R9 irq held", {31'd0, irqOut}, 1);
    // R10 read clears
    rdReg(5'h0C, v); chk("R10 status", v, 32'h80);
    rdReg(5'h0C, v); chk("R10 cleared", v, 0);
    // R9 ack drops irq next cycle
    @(negedge clk); wrEn = 1; addr = 5'h10; wrData = 0;
    @(negedge clk); wrEn = 0;
    chk("R9 irq dropped", {31'd0, irqOut}, 0);
    wrReg(5'h10, 32'h4);
    // R5 out-of-window pins and unselected channel
    pinsIn = 32'h8000_0081; cyc(6);
    chk("R5 out of window", {31'd0, irqOut}, 0);
    // R5 both bits: falling on ch 7
    wrReg(5'h08, 32'h80); pinsIn = 32'h0; cyc(6);
    chk("R5 both-edge fall", {31'd0, irqOut}, 1);
    ackAll();
    // R4/R5 random OR-mode trials
    prevPins = pinsIn;
    for (int t = 0; t < 40; t++) begin
      m1 = $urandom; m2 = $urandom & $urandom;
      wrReg(5'h04, m1); wrReg(5'h08, m2); wrReg(5'h10, 32'h4);
      ackAll();
      nxt = $urandom;
      exp = orHits(prevPins, nxt, m1, m2);
      pinsIn = nxt; cyc(6);
      chk("R4 random irq", {31'd0, irqOut}, {31'd0, |exp});
      rdReg(5'h0C, v); chk("R4 random status", v, exp);
      prevPins = nxt;
    end
    // R8 AND mode with nothing selected
    wrReg(5'h10, 0); wrReg(5'h04, 0); wrReg(5'h08, 0); rdReg(5'h0C, v);
    wrReg(5'h10, 32'h6); pinsIn = 32'h0; cyc(4); pinsIn = 32'hFFFF_FFFF; cyc(6);
    chk("R8 no select", {31'd0, irqOut}, 0);
    // R6 AND: ch4 high, ch5 low, ch6 both
    pinsIn = 32'h0; cyc(4);
    wrReg(5'h04, 32'h50); wrReg(5'h08, 32'h60);
    cyc(4); chk("R6 not met", {31'd0, irqOut}, 0);
    pinsIn = 32'h10; cyc(6);
    chk("R6 met irq", {31'd0, irqOut}, 1);
    rdReg(5'h0C, v); chk("R6 status", v, 32'h70);
    // R7 no refire while condition steady after ack
    wrReg(5'h10, 32'h2); wrReg(5'h10, 32'h6); cyc(6);
    chk("R7 no refire", {31'd0, irqOut}, 0);
    pinsIn = 32'h30; cyc(6);
    chk("R7 away", {31'd0, irqOut}, 0);
    pinsIn = 32'h10; cyc(6);
    chk("R7 rearmed", {31'd0, irqOut}, 1);
    rdReg(5'h00, v); chk("R3 raw", v, 32'h10);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule